// File: doc/BRIEF.md
# Line-fragmenting transfer engine with cycle-cost model

The block moves one transfer between two local memories. It takes a source byte address, a destination byte address and a byte length, and it starts on a one-cycle start strobe. The transfer is cut into fragments that never cross a destination line of `LINE_BYTES` bytes, and one bus request is issued for each fragment. The first and the last fragment may be partial lines. A fragment's size is set by the destination offset within its line and by the bytes still to move.

The engine also models the time that a transfer costs. A fixed start-up latency comes first, even when the length is zero. After it, every fragment occupies a slot of `BLOCK_CYC` cycles. When the source and the destination sit at different offsets within a line, each fragment must be rebuilt from two adjacent source lines by a byte rotation, and its slot grows by `MISALIGN_CYC` cycles. Each request reports the rotation amount, whether realignment is in force, and whether the fragment's source bytes span two source lines. A running cycle counter shows the time since the transfer was accepted. It stops at the total cost, and at that point a one-cycle done pulse is given.

Top module: `dma_line_frag`

## Requirements
- R1: After reset, busy, done and req_valid are 0 and cyc_count is 0.
- R2: Each request carries req_bytes = min(LINE_BYTES - (destination address mod LINE_BYTES), bytes remaining). The first request uses the given addresses. Each later request's source and destination addresses are those of the previous request plus its req_bytes, modulo 2^ADDR_W.
- R3: The number of requests equals the number of distinct destination lines that the byte range touches. A zero-length transfer issues no request.
- R4: The first request is valid in the cycle where cyc_count equals STARTUP_CYC. A zero-length transfer gives done in the cycle where cyc_count equals STARTUP_CYC.
- R5: Consecutive requests are PER cycles apart, measured on cyc_count. PER is BLOCK_CYC when (src - dst) mod LINE_BYTES is 0, and BLOCK_CYC + MISALIGN_CYC otherwise.
- R6: Done is given in the cycle where cyc_count equals STARTUP_CYC + N*PER, where N is the request count. cyc_count then holds that value until the next accepted start.
- R7: req_rot equals (src - dst) mod LINE_BYTES, and req_realign is 1 exactly when req_rot is nonzero. req_two_lines is 1 exactly when (source address mod LINE_BYTES) + req_bytes > LINE_BYTES.
- R8: A start strobe while busy is 1 is ignored. The running transfer's requests, timing and done are unchanged.
- R9: Done lasts exactly one cycle, and busy is 0 from the done cycle on. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken when not busy |
| src_addr | input | ADDR_W | Source byte address |
| dst_addr | input | ADDR_W | Destination byte address |
| xfer_len | input | LEN_W | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cyc_count | output | CNT_W | Cycles since the transfer was accepted |
| req_valid | output | 1 | One bus request this cycle |
| req_src_addr | output | ADDR_W | Source byte address of the fragment |
| req_dst_addr | output | ADDR_W | Destination byte address of the fragment |
| req_bytes | output | log2(LINE_BYTES)+1 | Fragment size in bytes |
| req_realign | output | 1 | Fragment needs a byte rotation |
| req_rot | output | log2(LINE_BYTES) | Rotation amount in bytes |
| req_two_lines | output | 1 | Source bytes span two source lines |

## Verification
The hardest case to reach from the ports is a start strobe that arrives while a transfer is still running. It has to land at a known point, and its effect must then be visible only through requests that did not change. The stimulus does this by pulsing a start with unrelated addresses and length a few cycles after launch, on a regular subset of a full sweep. The sweep covers every pair of source and destination line offsets, at lengths of zero, one byte, exactly one line, several lines and the maximum. In doing so it reaches partial first and last fragments, fragments whose source bytes straddle two lines, and address wrap-around. Every field of every request, and its timing, is predicted from the arithmetic alone.

// File: rtl/dma_frag_pkg.sv
package dma_frag_pkg;

  function automatic int unsigned span_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dma_frag_calc.sv
module dma_frag_calc #(
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic [OFF_W-1:0] dst_off,
  input  logic [OFF_W-1:0] src_off,
  input  logic [LEN_W-1:0] rem_len,
  output logic [LEN_W-1:0] frag_len,
  output logic             two_lines
);

  logic [LEN_W-1:0]   room;
  logic [OFF_W+1:0]   src_span;

  always_comb begin
    room      = LEN_W'(LINE_BYTES) - LEN_W'(dst_off);
    frag_len  = (rem_len < room) ? rem_len : room;
    src_span  = (OFF_W+2)'(src_off) + (OFF_W+2)'(frag_len[OFF_W:0]);
    two_lines = src_span > (OFF_W+2)'(LINE_BYTES);
  end

endmodule

// File: rtl/dma_cost_timer.sv
module dma_cost_timer
  import dma_frag_pkg::*;
#(
  parameter int STARTUP_CYC  = 200,
  parameter int BLOCK_CYC    = 8,
  parameter int MISALIGN_CYC = 16,
  parameter int CNT_W        = 24,
  localparam int SLOT_MAX    = span_max(STARTUP_CYC, BLOCK_CYC + MISALIGN_CYC),
  localparam int SLOT_W      = $clog2(SLOT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             misaligned,
  input  logic             more,
  output logic             running,
  output logic             slot_end,
  output logic [CNT_W-1:0] cyc_count
);

  logic [SLOT_W-1:0] slot_left;
  logic [SLOT_W-1:0] per_q;

  assign slot_end = running && (slot_left == SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      slot_left <= '0;
      per_q     <= '0;
      cyc_count <= '0;
    end else if (launch) begin
      running   <= 1'b1;
      slot_left <= SLOT_W'(STARTUP_CYC);
      per_q     <= misaligned ? SLOT_W'(BLOCK_CYC + MISALIGN_CYC) : SLOT_W'(BLOCK_CYC);
      cyc_count <= '0;
    end else if (running) begin
      cyc_count <= cyc_count + CNT_W'(1);
      if (slot_end) begin
        if (more) slot_left <= per_q;
        else      running   <= 1'b0;
      end else begin
        slot_left <= slot_left - SLOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/dma_line_frag.sv
module dma_line_frag #(
  parameter int ADDR_W       = 16,
  parameter int LEN_W        = 12,
  parameter int LINE_BYTES   = 128,
  parameter int STARTUP_CYC  = 200,
  parameter int BLOCK_CYC    = 8,
  parameter int MISALIGN_CYC = 16,
  parameter int CNT_W        = 24,
  localparam int OFF_W       = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_src_addr,
  output logic [ADDR_W-1:0] req_dst_addr,
  output logic [OFF_W:0]    req_bytes,
  output logic              req_realign,
  output logic [OFF_W-1:0]  req_rot,
  output logic              req_two_lines
);

  logic [ADDR_W-1:0] cur_src;
  logic [ADDR_W-1:0] cur_dst;
  logic [LEN_W-1:0]  rem_len;
  logic [LEN_W-1:0]  frag_len;
  logic              frag_two;
  logic [OFF_W-1:0]  rot_in;
  logic              accept;
  logic              more;
  logic              slot_end;
  logic              running;

  assign rot_in = src_addr[OFF_W-1:0] - dst_addr[OFF_W-1:0];
  assign accept = start && !running;
  assign more   = (rem_len != '0);
  assign busy   = running;

  dma_frag_calc #(
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES)
  ) i_calc (
    .dst_off   (cur_dst[OFF_W-1:0]),
    .src_off   (cur_src[OFF_W-1:0]),
    .rem_len   (rem_len),
    .frag_len  (frag_len),
    .two_lines (frag_two)
  );

  dma_cost_timer #(
    .STARTUP_CYC  (STARTUP_CYC),
    .BLOCK_CYC    (BLOCK_CYC),
    .MISALIGN_CYC (MISALIGN_CYC),
    .CNT_W        (CNT_W)
  ) i_timer (
    .clk        (clk),
    .rst        (rst),
    .launch     (accept),
    .misaligned (rot_in != '0),
    .more       (more),
    .running    (running),
    .slot_end   (slot_end),
    .cyc_count  (cyc_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_src       <= '0;
      cur_dst       <= '0;
      rem_len       <= '0;
      done          <= 1'b0;
      req_valid     <= 1'b0;
      req_src_addr  <= '0;
      req_dst_addr  <= '0;
      req_bytes     <= '0;
      req_realign   <= 1'b0;
      req_rot       <= '0;
      req_two_lines <= 1'b0;
    end else begin
      done      <= 1'b0;
      req_valid <= 1'b0;
      if (accept) begin
        cur_src     <= src_addr;
        cur_dst     <= dst_addr;
        rem_len     <= xfer_len;
        req_rot     <= rot_in;
        req_realign <= (rot_in != '0);
      end else if (slot_end) begin
        if (more) begin
          req_valid     <= 1'b1;
          req_src_addr  <= cur_src;
          req_dst_addr  <= cur_dst;
          req_bytes     <= frag_len[OFF_W:0];
          req_two_lines <= frag_two;
          cur_src       <= cur_src + ADDR_W'(frag_len);
          cur_dst       <= cur_dst + ADDR_W'(frag_len);
          rem_len       <= rem_len - frag_len;
        end else begin
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_line_frag_chk.sv
module dma_line_frag_chk #(
  parameter int LINE_BYTES  = 128,
  parameter int STARTUP_CYC = 200,
  parameter int CNT_W       = 24,
  localparam int OFF_W      = $clog2(LINE_BYTES)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cyc_count,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_dst_off,
  input logic [OFF_W:0]   req_bytes,
  input logic             req_realign,
  input logic [OFF_W-1:0] req_rot,
  input logic             req_two_lines
);

  a_r2_frag_fits: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_bytes != '0) &&
      ((OFF_W+2)'(req_dst_off) + (OFF_W+2)'(req_bytes) <= (OFF_W+2)'(LINE_BYTES)));

  a_r4_no_early_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (cyc_count >= CNT_W'(STARTUP_CYC)));

  a_r6_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(cyc_count));

  a_r7_aligned_one_line: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_realign) |-> !req_two_lines);

  a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(req_rot) && $stable(req_realign)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind dma_line_frag dma_line_frag_chk #(
  .LINE_BYTES  (LINE_BYTES),
  .STARTUP_CYC (STARTUP_CYC),
  .CNT_W       (CNT_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .cyc_count     (cyc_count),
  .req_valid     (req_valid),
  .req_dst_off   (req_dst_addr[OFF_W-1:0]),
  .req_bytes     (req_bytes),
  .req_realign   (req_realign),
  .req_rot       (req_rot),
  .req_two_lines (req_two_lines)
);

// File: tb/test_dma_line_frag.sv
`timescale 1ns/100ps
module test_dma_line_frag;

  localparam int AW = 8;
  localparam int LW = 7;
  localparam int LB = 16;
  localparam int SC = 20;
  localparam int MC = 4;
  localparam int BC = 3;
  localparam int CW = 16;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic busy, done, req_valid, req_realign, req_two_lines;
  logic [CW-1:0] cyc_count;
  logic [AW-1:0] req_src_addr, req_dst_addr;
  logic [OW:0]   req_bytes;
  logic [OW-1:0] req_rot;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dma_line_frag #(
    .ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .STARTUP_CYC(SC),
    .BLOCK_CYC(BC), .MISALIGN_CYC(MC), .CNT_W(CW)
  ) i_dma_line_frag (
    .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_len(xfer_len), .busy(busy), .done(done), .cyc_count(cyc_count),
    .req_valid(req_valid), .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
    .req_bytes(req_bytes), .req_realign(req_realign), .req_rot(req_rot),
    .req_two_lines(req_two_lines)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input int s, input int d, input int l, input bit inject);
    int rot, per, n, k, e_src, e_dst, rem, e_bytes, room, tcost, waited;
    bit finished;
    rot = (s - d) & (LB - 1);
    per = BC + ((rot != 0) ? MC : 0);
    n = (l == 0) ? 0 : ((d % LB) + l - 1) / LB + 1;
    tcost = SC + n * per;
    e_src = s; e_dst = d; rem = l; k = 0; finished = 0; waited = 0;
    @(negedge clk);
    src_addr = AW'(s); dst_addr = AW'(d); xfer_len = LW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!finished && waited < 2000) begin
      if (inject && waited == 3) begin
        src_addr = AW'(s + 5); dst_addr = AW'(d + 9); xfer_len = LW'(l + 3); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (req_valid) begin
        room = LB - (e_dst % LB);
        e_bytes = (rem < room) ? rem : room;
        chk(k < n, "R3 request count bound", k, n);
        chk(int'(req_dst_addr) == e_dst, inject ? "R8 dst after ignored start" : "R2 dst addr",
            int'(req_dst_addr), e_dst);
        chk(int'(req_src_addr) == e_src, "R2 src addr", int'(req_src_addr), e_src);
        chk(int'(req_bytes) == e_bytes, "R2 fragment bytes", int'(req_bytes), e_bytes);
        chk(int'(req_rot) == rot, "R7 rotation", int'(req_rot), rot);
        chk(req_realign == (rot != 0), "R7 realign flag", int'(req_realign), int'(rot != 0));
        chk(req_two_lines == (((e_src % LB) + e_bytes) > LB), "R7 two source lines",
            int'(req_two_lines), int'(((e_src % LB) + e_bytes) > LB));
        chk(int'(cyc_count) == SC + k * per, (k == 0) ? "R4 first request time" : "R5 request spacing",
            int'(cyc_count), SC + k * per);
        e_src = (e_src + e_bytes) & 255;
        e_dst = (e_dst + e_bytes) & 255;
        rem = rem - e_bytes;
        k++;
      end
      if (done) begin
        chk(k == n, "R3 request count", k, n);
        chk(int'(cyc_count) == tcost, (n == 0) ? "R4 zero length done time" : "R6 total cost",
            int'(cyc_count), tcost);
        chk(!busy, "R9 idle at done", int'(busy), 0);
        finished = 1;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    if (!finished) begin
      chk(0, "R6 transfer timed out", waited, tcost);
    end else begin
      chk(!done, "R9 done single cycle", int'(done), 0);
      chk(int'(cyc_count) == tcost, "R6 count holds", int'(cyc_count), tcost);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lens [4] = '{0, 1, 16, 37};
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(!req_valid, "R1 req after reset", int'(req_valid), 0);
    chk(cyc_count == '0, "R1 counter after reset", int'(cyc_count), 0);
    for (int doff = 0; doff < LB; doff++) begin
      for (int soff = 0; soff < LB; soff++) begin
        for (int li = 0; li < 4; li++) begin
          run_xfer(8'h90 + soff, 8'h40 + doff, lens[li], ((doff + soff + li) % 5) == 0);
        end
      end
    end
    run_xfer(8'hF3, 8'hFB, 127, 1'b0);
    run_xfer(8'h05, 8'h20, 127, 1'b1);
    run_xfer(8'hEE, 8'hF1, 40, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule